// File: doc/BRIEF.md
# Trace Capture Buffer with Selectable Full Policy

This block is an on-chip store for trace words. A trace source presents words on a valid/ready stream input; each accepted word is written into an internal RAM array. A debugger reads the captured words back, oldest first, through a small register-style read port that also exposes the status flags and the fill level. Its job is to soak up bursts from the trace source so that the reader can drain at its own pace.

A mode input picks one of two full-buffer policies. In lossless mode a full buffer drops the stream's ready, so the source stalls and no word is lost. In overwrite mode the input stays ready while capture is on; a word that arrives at a full buffer replaces the oldest stored word, and a sticky wrapped flag records that data has been lost. The mode is taken from its input only while capture is off, so the policy cannot change in the middle of a capture. Stream rules: a word moves on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. It is low whenever `cap_en` is low, and in lossless mode it is low whenever the buffer is full.

The read port is strobe-based. `rd_en` with a selector returns one word on `rd_data` in the next cycle, and `rd_valid` marks that cycle. Only a read of the data selector removes a word from the buffer. DEPTH must be at least 2.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the buffer is empty. `st_empty`=1, `st_full`=0, `st_wrapped`=0 and `fill_level`=0, and the policy is lossless.
- R2: While `cap_en`=0, `in_ready` is 0 and no input word is stored. The fill level does not change.
- R3: In lossless mode (latched mode bit 0) a full buffer drives `in_ready` low. The fill level never exceeds DEPTH, and `st_full` is 1 exactly when it equals DEPTH.
- R4: In overwrite mode (latched mode bit 1), `in_ready` equals `cap_en`. A word accepted into a full buffer with no pop in the same cycle discards the oldest stored word and leaves the fill level at DEPTH.
- R5: The first overwrite sets `st_wrapped`. The flag then stays set until reset.
- R6: `mode_in` is latched on every clock edge where `cap_en`=0. A change of `mode_in` while `cap_en`=1 has no effect on the policy.
- R7: A read with `rd_sel`=0 (data) from a non-empty buffer returns the oldest stored word on `rd_data` one cycle later, with `rd_valid`=1, and removes that word.
- R8: A data read from an empty buffer returns all ones and moves nothing. The fill level stays 0.
- R9: An accepted write and a successful data pop in the same cycle leave the fill level unchanged.
- R10: `rd_sel`=1 returns status with bit0 = empty, bit1 = full, bit2 = wrapped and zeros above. `rd_sel`=2 returns the fill level zero-extended. `rd_sel`=3 returns zero. None of these reads changes the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| mode_in | input | 1 | Full policy: 0 lossless, 1 overwrite; latched while cap_en=0 |
| in_valid | input | 1 | Trace word valid |
| in_ready | output | 1 | Buffer can accept a word |
| in_data | input | W | Trace word |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read selector: 0 data, 1 status, 2 level, 3 none |
| rd_data | output | W | Read result, valid one cycle after rd_en |
| rd_valid | output | 1 | rd_data holds a fresh result |
| st_empty | output | 1 | Buffer empty |
| st_full | output | 1 | Buffer holds DEPTH words |
| st_wrapped | output | 1 | Sticky: an overwrite has occurred |
| fill_level | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
Several rules are checked on every cycle by assertions: the ready rules of both policies and of disabled capture, the bound on the fill level, the wrapped flag staying set, the mode staying fixed while capture runs, the all-ones result of an empty read, and the fill level holding still under a write and a pop in the same cycle. Other behaviour needs the bench's scenarios to show it. These are the order of the words read back, the loss of exactly the oldest words after several overwrites, the rejection of a mode change made during capture, and the contents returned for each read selector.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_LEVEL = 2'd2,
    SEL_NONE  = 2'd3
  } rsel_e;
endpackage

// File: rtl/tbuf_ctrl.sv
module tbuf_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          mode_in,
  input  logic          wr_req,
  input  logic          pop_req,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          pop_ok,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          wrapped,
  output logic          mode_q
);
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          overwrite;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + AW'(1);
  endfunction

  assign full      = (level == LVL_MAX);
  assign empty     = (level == '0);
  assign in_ready  = cap_en && (mode_q || !full);
  assign wr_en     = wr_req && in_ready;
  assign pop_ok    = pop_req && !empty;
  assign overwrite = wr_en && full && !pop_ok;
  assign wr_addr   = wr_ptr;
  assign rd_addr   = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (!cap_en) begin
      mode_q <= mode_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      wrapped <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok || overwrite) rd_ptr <= ptr_next(rd_ptr);
      if (overwrite) wrapped <= 1'b1;
      unique case ({wr_en && !overwrite, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/tbuf_ram.sv
module tbuf_ram #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rword
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rword = store[raddr];
endmodule

// File: rtl/tbuf_rdport.sv
module tbuf_rdport
  import tbuf_pkg::*;
#(
  parameter int W = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  input  logic          pop_ok,
  input  logic [W-1:0]  mem_word,
  input  logic          empty,
  input  logic          full,
  input  logic          wrapped,
  input  logic [LW-1:0] level,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid
);
  logic [W-1:0] stat_w, lvl_w, sel_w;

  always_comb begin
    stat_w = '0;
    stat_w[2:0] = {wrapped, full, empty};
    lvl_w = '0;
    lvl_w[LW-1:0] = level;
    unique case (rsel_e'(rd_sel))
      SEL_DATA:  sel_w = pop_ok ? mem_word : '1;
      SEL_STAT:  sel_w = stat_w;
      SEL_LEVEL: sel_w = lvl_w;
      default:   sel_w = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_w;
    end
  end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tbuf_pkg::*;
#(
  parameter int W = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          mode_in,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic          st_empty,
  output logic          st_full,
  output logic          st_wrapped,
  output logic [LW-1:0] fill_level
);
  logic          wr_en, pop_ok, mode_q, pop_req;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [W-1:0]  mem_word;

  assign pop_req = rd_en && (rsel_e'(rd_sel) == SEL_DATA);

  tbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode_in(mode_in),
    .wr_req(in_valid), .pop_req(pop_req), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .pop_ok(pop_ok),
    .level(fill_level), .full(st_full), .empty(st_empty),
    .wrapped(st_wrapped), .mode_q(mode_q)
  );

  tbuf_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
    .raddr(rd_addr), .rword(mem_word)
  );

  tbuf_rdport #(.W(W), .LW(LW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
    .pop_ok(pop_ok), .mem_word(mem_word), .empty(st_empty),
    .full(st_full), .wrapped(st_wrapped), .level(fill_level),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/tbuf_chk.sv
module tbuf_chk #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_en,
  input logic          mode_q,
  input logic          in_valid,
  input logic          in_ready,
  input logic          rd_en,
  input logic [1:0]    rd_sel,
  input logic          pop_ok,
  input logic [W-1:0]  rd_data,
  input logic          st_empty,
  input logic          st_full,
  input logic          st_wrapped,
  input logic [LW-1:0] fill_level
);
  a_r2_no_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !in_ready);
  a_r3_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !mode_q && st_full) |-> !in_ready);
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LW'(DEPTH));
  a_r4_circ_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && mode_q) |-> in_ready);
  a_r5_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st_wrapped |=> st_wrapped);
  a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> $stable(mode_q));
  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd0 && st_empty && !(in_valid && in_ready))
      |=> (rd_data == '1 && fill_level == '0));
  a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && pop_ok) |=> $stable(fill_level));
  a_r3_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_full && st_empty));
endmodule

bind trace_capture_buf tbuf_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode_q(mode_q),
  .in_valid(in_valid), .in_ready(in_ready), .rd_en(rd_en), .rd_sel(rd_sel),
  .pop_ok(pop_ok), .rd_data(rd_data), .st_empty(st_empty),
  .st_full(st_full), .st_wrapped(st_wrapped), .fill_level(fill_level)
);

// File: tb/tb_trace_capture_buf.sv
module tb_trace_capture_buf;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0, cap_en = 0, mode_in = 0, in_valid = 0, rd_en = 0;
  logic [W-1:0] in_data = '0;
  logic [1:0] rd_sel = 2'd0;
  logic in_ready, rd_valid, st_empty, st_full, st_wrapped;
  logic [W-1:0] rd_data;
  logic [LW-1:0] fill_level;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] sb_q[$];
  bit m_wrapped = 0, m_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_capture_buf #(.W(W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode_in(mode_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid),
    .st_empty(st_empty), .st_full(st_full), .st_wrapped(st_wrapped),
    .fill_level(fill_level)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_status(input string req);
    chk(req, W'(fill_level), W'(sb_q.size()));
    chk(req, W'({st_wrapped, st_full, st_empty}),
        W'({m_wrapped, sb_q.size() == DEPTH, sb_q.size() == 0}));
  endtask

  // driver: offer one word for one cycle, push expected item when accepted
  task automatic push(input logic [W-1:0] d, input bit with_pop, output bit acc);
    logic [W-1:0] exp_rd;
    bit popped;
    @(negedge clk);
    in_valid = 1; in_data = d;
    rd_en = with_pop; rd_sel = 2'd0;
    #1;
    acc = in_ready;
    popped = with_pop && sb_q.size() != 0;
    exp_rd = popped ? sb_q[0] : '1;
    if (popped) void'(sb_q.pop_front());
    if (acc) begin
      if (sb_q.size() == DEPTH) begin
        void'(sb_q.pop_front());
        m_wrapped = 1;
      end
      sb_q.push_back(d);
    end
    @(negedge clk);
    in_valid = 0; rd_en = 0;
    if (with_pop) chk("R9 read data", rd_data, exp_rd);
  endtask

  // monitor-side read: pops the expected item and compares
  task automatic rd(input logic [1:0] sel, input string req);
    logic [W-1:0] exp;
    @(negedge clk);
    rd_en = 1; rd_sel = sel;
    case (sel)
      2'd0: exp = (sb_q.size() != 0) ? sb_q.pop_front() : '1;
      2'd1: exp = W'({m_wrapped, sb_q.size() == DEPTH, sb_q.size() == 0});
      2'd2: exp = W'(sb_q.size());
      default: exp = '0;
    endcase
    @(negedge clk);
    rd_en = 0;
    chk({req, " rd_valid"}, W'(rd_valid), W'(1));
    chk(req, rd_data, exp);
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk);
    cap_en = 0; mode_in = m; m_mode = m;
    @(negedge clk);
    cap_en = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_status("R1 reset");
    // R2 disabled capture
    chk("R2 ready low", W'(in_ready), W'(0));
    push(16'hdead, 0, acc);
    chk("R2 not accepted", W'(acc), W'(0));
    chk_status("R2 level");
    // R3 lossless mode fill
    set_mode(0);
    for (int i = 0; i < DEPTH; i++) begin
      push(16'h1000 + 16'(i), 0, acc);
      chk("R3 accept", W'(acc), W'(1));
    end
    chk_status("R3 full");
    push(16'hbeef, 0, acc);
    chk("R3 backpressure", W'(acc), W'(0));
    chk_status("R3 level sat");
    // R10 status/level reads have no side effect
    rd(2'd1, "R10 status");
    rd(2'd2, "R10 level");
    rd(2'd3, "R10 none");
    chk_status("R10 unchanged");
    // R7 ordered reads
    for (int i = 0; i < 3; i++) rd(2'd0, "R7 order");
    chk_status("R7 level");
    // R9 simultaneous write and pop
    push(16'h2000, 1, acc);
    chk("R9 accept", W'(acc), W'(1));
    chk_status("R9 level");
    while (sb_q.size() != 0) rd(2'd0, "R7 drain");
    // R8 empty read
    rd(2'd0, "R8 empty read");
    chk_status("R8 level");
    // R6 mode change while enabled is ignored
    @(negedge clk);
    mode_in = 1;
    for (int i = 0; i < DEPTH; i++) push(16'h3000 + 16'(i), 0, acc);
    push(16'h3fff, 0, acc);
    chk("R6 still lossless", W'(acc), W'(0));
    chk_status("R6 no wrap");
    while (sb_q.size() != 0) rd(2'd0, "R6 drain");
    // R4/R5 overwrite mode
    set_mode(1);
    for (int i = 0; i < DEPTH + 3; i++) begin
      push(16'h4000 + 16'(i), 0, acc);
      chk("R4 always ready", W'(acc), W'(1));
    end
    chk_status("R5 wrapped set");
    chk("R4 ready when full", W'(in_ready), W'(1));
    rd(2'd1, "R10 status wrapped");
    push(16'h4100, 1, acc);
    chk_status("R9 circ full level");
    while (sb_q.size() != 0) rd(2'd0, "R4 oldest dropped");
    chk_status("R5 sticky");
    @(negedge clk);
    cap_en = 0;
    @(negedge clk);
    chk("R2 ready off", W'(in_ready), W'(0));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule